// File: doc/BRIEF.md
# Telephone Ring Wake Detector

This block watches the ring-indication lines of a telephone or modem interface and turns activity on them into one-cycle wake requests for a power controller. It handles five sources. Two candidate ring pins feed one ring path, and a select bit chooses between them. Two ring-indicator pins each have their own path. A date/time match pulse, which arrives in the same clock domain, has a path of its own.

Each source has an enable bit. When the ring path is in edge mode, it fires on every falling edge of the selected pin. In train mode it fires only when falling edges keep arriving faster than a set rate for a qualification window. It fires once per train and re-arms only after the line has gone quiet. The four pin inputs are asynchronous and pass through synchronizer chains before any edge is seen. The time base for train mode is a prescaled tick. `TICK_DIV`, `GAP_LIMIT` and `QUAL_LEN` are set so that the gap limit is 1/16 s and the window is 0.19 s.

Top module: `ring_wake_detector`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, every wake output is 0.
- R2: A pin input is sampled through `SYNC_STAGES` flops. With the default of 2, a high-to-low change on an enabled pin gives a wake pulse that starts at the third rising clock edge after the change.
- R3: `cfg_src_sel` chooses the ring pin: 0 selects `ring_a` and 1 selects `ring_b`. Falling edges on the pin that is not selected have no effect on `wake_ring`.
- R4: With `cfg_train_mode`=0 and `cfg_ring_en`=1, every falling edge of the selected ring pin gives exactly one `wake_ring` pulse.
- R5: With `cfg_train_mode`=1, `wake_ring` pulses once after two conditions hold. First, falling edges have kept coming with no gap longer than `GAP_LIMIT` ticks. Second, `QUAL_LEN` ticks have passed since the first edge of the train. A tick is `TICK_DIV` clock cycles.
- R6: In train mode, a gap longer than `GAP_LIMIT` ticks cancels qualification and re-arms the detector. A train that keeps running gives only one pulse. Trains that are too short or too slow give none.
- R7: When `cfg_ring_en`=0, `wake_ring` stays 0.
- R8: A falling edge on `ri1` pulses `wake_ri1` when `cfg_ri1_en`=1. When `cfg_ri1_en`=0 it has no effect.
- R9: A falling edge on `ri2` pulses `wake_ri2` when `cfg_ri2_en`=1. When `cfg_ri2_en`=0 it has no effect.
- R10: `wake_tm` is high in the cycle after a cycle in which both `tm_match` and `cfg_tm_en` are 1. Otherwise it is low.
- R11: `wake_any` is high in exactly the cycles in which at least one of the four source wake outputs is high.
- R12: `wake_ring`, `wake_ri1` and `wake_ri2` are never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_a | input | 1 | Ring pin chosen when the select bit is 0 (asynchronous) |
| ring_b | input | 1 | Alternate ring pin chosen when the select bit is 1 (asynchronous) |
| ri1 | input | 1 | First ring-indicator pin (asynchronous) |
| ri2 | input | 1 | Second ring-indicator pin (asynchronous) |
| tm_match | input | 1 | One-cycle date/time match pulse (synchronous) |
| cfg_src_sel | input | 1 | Ring pin select |
| cfg_train_mode | input | 1 | 0: single falling edge, 1: pulse-train qualification |
| cfg_ring_en | input | 1 | Ring path enable |
| cfg_ri1_en | input | 1 | ri1 path enable |
| cfg_ri2_en | input | 1 | ri2 path enable |
| cfg_tm_en | input | 1 | Match path enable |
| wake_ring | output | 1 | Ring wake pulse |
| wake_ri1 | output | 1 | ri1 wake pulse |
| wake_ri2 | output | 1 | ri2 wake pulse |
| wake_tm | output | 1 | Match wake pulse |
| wake_any | output | 1 | OR of all wake pulses |

## Verification
The assertions check local invariants on every cycle:
- A disabled path never pulses.
- The match wake comes only from a match that was enabled one cycle earlier.
- The synchronized fall strobes and the train hit never last two cycles.
- The qualification counter stays within its bound.

Some behaviour spans tens of cycles and cannot be written as a simple property: that the ring pin is chosen by the select bit, the exact three-edge latency, and that train qualification fires once, re-arms, and rejects short and slow trains. The bench's cycle model and its pulse-count scenarios cover these.

// File: rtl/rwd_pkg.sv
package rwd_pkg;
   localparam int NUM_PINS   = 4;
   localparam int PIN_RING_A = 0;
   localparam int PIN_RING_B = 1;
   localparam int PIN_RI1    = 2;
   localparam int PIN_RI2    = 3;
endpackage

// File: rtl/rwd_sync_fall.sv
module rwd_sync_fall #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rwd_sync_fall: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         prev  <= chain[STAGES-1];
      end
   end

   assign fall = prev & ~chain[STAGES-1];

   AST_FALL_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall) else $error("fall strobe longer than one cycle"); // R12
endmodule

// File: rtl/rwd_train_qual.sv
module rwd_train_qual #(
   parameter int TICK_DIV  = 250000,
   parameter int GAP_LIMIT = 62,
   parameter int QUAL_LEN  = 190
) (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_in,
   output logic hit
);
   if (TICK_DIV < 2) begin : g_bad_div
      $error("rwd_train_qual: TICK_DIV must be at least 2");
   end
   if (GAP_LIMIT < 1) begin : g_bad_gap
      $error("rwd_train_qual: GAP_LIMIT must be at least 1");
   end
   if (QUAL_LEN < 1) begin : g_bad_len
      $error("rwd_train_qual: QUAL_LEN must be at least 1");
   end

   localparam int PW = $clog2(TICK_DIV);
   localparam int GW = $clog2(GAP_LIMIT + 2);
   localparam int RW = $clog2(QUAL_LEN + 1);
   localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
   localparam logic [GW-1:0] GAP_MAX  = GW'(GAP_LIMIT);
   localparam logic [GW-1:0] GAP_IDLE = GW'(GAP_LIMIT + 1);
   localparam logic [RW-1:0] RUN_MAX  = RW'(QUAL_LEN);

   logic [PW-1:0] pre_q;
   logic [GW-1:0] gap_q;
   logic [RW-1:0] run_q;
   logic          active_q, fired_q;
   logic          tick, lost;

   assign tick = (pre_q == PRE_LAST);
   assign lost = tick && !edge_in && (gap_q == GAP_MAX);
   assign hit  = active_q && (run_q == RUN_MAX) && !fired_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q    <= '0;
         gap_q    <= GAP_IDLE;
         run_q    <= '0;
         active_q <= 1'b0;
         fired_q  <= 1'b0;
      end else begin
         pre_q <= tick ? '0 : pre_q + 1'b1;
         if (edge_in)
            gap_q <= '0;
         else if (tick && gap_q <= GAP_MAX)
            gap_q <= gap_q + 1'b1;

         if (edge_in)
            active_q <= 1'b1;
         else if (lost)
            active_q <= 1'b0;

         if ((edge_in && !active_q) || lost)
            run_q <= '0;
         else if (tick && active_q && run_q < RUN_MAX)
            run_q <= run_q + 1'b1;

         if (lost)
            fired_q <= 1'b0;
         else if (hit)
            fired_q <= 1'b1;
      end
   end

   AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RUN_MAX) else $error("qualification counter overran"); // R5
   AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !hit) else $error("train hit repeated"); // R6
endmodule

// File: rtl/ring_wake_detector.sv
module ring_wake_detector
   import rwd_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int TICK_DIV    = 250000,
   parameter int GAP_LIMIT   = 62,
   parameter int QUAL_LEN    = 190
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ring_a,
   input  logic ring_b,
   input  logic ri1,
   input  logic ri2,
   input  logic tm_match,
   input  logic cfg_src_sel,
   input  logic cfg_train_mode,
   input  logic cfg_ring_en,
   input  logic cfg_ri1_en,
   input  logic cfg_ri2_en,
   input  logic cfg_tm_en,
   output logic wake_ring,
   output logic wake_ri1,
   output logic wake_ri2,
   output logic wake_tm,
   output logic wake_any
);
   logic [NUM_PINS-1:0] pin_raw, pin_fall;
   logic                ring_fall, train_hit;

   assign pin_raw[PIN_RING_A] = ring_a;
   assign pin_raw[PIN_RING_B] = ring_b;
   assign pin_raw[PIN_RI1]    = ri1;
   assign pin_raw[PIN_RI2]    = ri2;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      rwd_sync_fall #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (pin_raw[i]),
         .fall (pin_fall[i])
      );
   end

   assign ring_fall = cfg_src_sel ? pin_fall[PIN_RING_B] : pin_fall[PIN_RING_A];

   rwd_train_qual #(
      .TICK_DIV (TICK_DIV),
      .GAP_LIMIT(GAP_LIMIT),
      .QUAL_LEN (QUAL_LEN)
   ) u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .edge_in(ring_fall),
      .hit    (train_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_ring <= 1'b0;
         wake_ri1  <= 1'b0;
         wake_ri2  <= 1'b0;
         wake_tm   <= 1'b0;
      end else begin
         wake_ring <= cfg_ring_en & (cfg_train_mode ? train_hit : ring_fall);
         wake_ri1  <= cfg_ri1_en & pin_fall[PIN_RI1];
         wake_ri2  <= cfg_ri2_en & pin_fall[PIN_RI2];
         wake_tm   <= cfg_tm_en & tm_match;
      end
   end

   assign wake_any = wake_ring | wake_ri1 | wake_ri2 | wake_tm;

   AST_RING_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ring_en |=> !wake_ring) else $error("ring wake while disabled"); // R7
   AST_RI1_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ri1_en |=> !wake_ri1) else $error("ri1 wake while disabled"); // R8
   AST_RI2_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ri2_en |=> !wake_ri2) else $error("ri2 wake while disabled"); // R9
   AST_TM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_tm |-> $past(tm_match & cfg_tm_en)) else $error("match wake without cause"); // R10
endmodule

// File: tb/ring_wake_detector_bench.sv
`timescale 1ns/1ps
module ring_wake_detector_bench;
   localparam int TDIV = 4;
   localparam int GLIM = 3;
   localparam int QLEN = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ring_a = 1'b1, ring_b = 1'b1, ri1 = 1'b1, ri2 = 1'b1, tm_match = 1'b0;
   logic cfg_src_sel = 1'b0, cfg_train_mode = 1'b0, cfg_ring_en = 1'b0;
   logic cfg_ri1_en = 1'b0, cfg_ri2_en = 1'b0, cfg_tm_en = 1'b0;
   logic wake_ring, wake_ri1, wake_ri2, wake_tm, wake_any;

   always #2 clk = ~clk;

   ring_wake_detector #(.SYNC_STAGES(2), .TICK_DIV(TDIV), .GAP_LIMIT(GLIM), .QUAL_LEN(QLEN)) u_ring_wake_detector (
      .clk(clk), .rst_n(rst_n), .ring_a(ring_a), .ring_b(ring_b), .ri1(ri1), .ri2(ri2),
      .tm_match(tm_match), .cfg_src_sel(cfg_src_sel), .cfg_train_mode(cfg_train_mode),
      .cfg_ring_en(cfg_ring_en), .cfg_ri1_en(cfg_ri1_en), .cfg_ri2_en(cfg_ri2_en),
      .cfg_tm_en(cfg_tm_en), .wake_ring(wake_ring), .wake_ri1(wake_ri1), .wake_ri2(wake_ri2),
      .wake_tm(wake_tm), .wake_any(wake_any));

   int n_checks = 0;
   int n_err    = 0;
   bit done     = 1'b0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference: pin histories (bit0 newest sample) and integer train state
   int  h_a, h_b, h_1, h_2;
   int  m_tick_ph, m_gap, m_run;
   bit  m_act, m_fired;
   bit  e_ring, e_ri1, e_ri2, e_tm;

   function automatic bit fell(input int h);
      return ((h >> 2) & 1) == 1 && ((h >> 1) & 1) == 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_a = 0; h_b = 0; h_1 = 0; h_2 = 0;
         m_tick_ph = 0; m_gap = GLIM + 1; m_run = 0; m_act = 0; m_fired = 0;
         e_ring = 0; e_ri1 = 0; e_ri2 = 0; e_tm = 0;
      end else begin
         bit fa, fb, fsel, tk, lost, fire;
         fa   = fell(h_a);
         fb   = fell(h_b);
         fsel = cfg_src_sel ? fb : fa;
         tk   = (m_tick_ph == TDIV - 1);
         fire = m_act && m_run == QLEN && !m_fired;
         lost = tk && !fsel && m_gap == GLIM;
         e_ring = cfg_ring_en && (cfg_train_mode ? fire : fsel);
         e_ri1  = cfg_ri1_en && fell(h_1);
         e_ri2  = cfg_ri2_en && fell(h_2);
         e_tm   = cfg_tm_en && tm_match;
         if ((fsel && !m_act) || lost) m_run = 0;
         else if (tk && m_act && m_run < QLEN) m_run++;
         if (lost) m_fired = 0; else if (fire) m_fired = 1;
         if (fsel) m_act = 1; else if (lost) m_act = 0;
         if (fsel) m_gap = 0; else if (tk && m_gap <= GLIM) m_gap++;
         m_tick_ph = tk ? 0 : m_tick_ph + 1;
         h_a = ((h_a << 1) | int'(ring_a)) & 7;
         h_b = ((h_b << 1) | int'(ring_b)) & 7;
         h_1 = ((h_1 << 1) | int'(ri1)) & 7;
         h_2 = ((h_2 << 1) | int'(ri2)) & 7;
      end
   end

   // per-cycle comparison and pulse counters
   int  c_ring, c_ri1, c_ri2, c_tm, c_any;
   bit  p_ring, p_ri1, p_ri2;
   bit  compare_on = 1'b0;

   always @(negedge clk) begin
      if (compare_on && rst_n) begin
         check(wake_ring == e_ring, "R4 R5 wake_ring vs model", wake_ring, e_ring);
         check(wake_ri1 == e_ri1, "R8 wake_ri1 vs model", wake_ri1, e_ri1);
         check(wake_ri2 == e_ri2, "R9 wake_ri2 vs model", wake_ri2, e_ri2);
         check(wake_tm == e_tm, "R10 wake_tm vs model", wake_tm, e_tm);
         check(wake_any == (e_ring | e_ri1 | e_ri2 | e_tm), "R11 wake_any vs model",
               wake_any, e_ring | e_ri1 | e_ri2 | e_tm);
         check(!(p_ring && wake_ring) && !(p_ri1 && wake_ri1) && !(p_ri2 && wake_ri2),
               "R12 back-to-back pulse", 1, 0);
         p_ring = wake_ring; p_ri1 = wake_ri1; p_ri2 = wake_ri2;
         c_ring += int'(wake_ring); c_ri1 += int'(wake_ri1); c_ri2 += int'(wake_ri2);
         c_tm += int'(wake_tm); c_any += int'(wake_any);
      end
   end

   task automatic clear_counts();
      c_ring = 0; c_ri1 = 0; c_ri2 = 0; c_tm = 0; c_any = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // pin: 0 ring_a, 1 ring_b, 2 ri1, 3 ri2
   task automatic set_pin(input int pin, input logic v);
      case (pin)
         0: ring_a = v;
         1: ring_b = v;
         2: ri1 = v;
         default: ri2 = v;
      endcase
   endtask

   task automatic pulses(input int pin, input int count, input int period);
      for (int k = 0; k < count; k++) begin
         set_pin(pin, 1'b0);
         idle(period / 2);
         set_pin(pin, 1'b1);
         idle(period - period / 2);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
         $finish;
      end
   end

   initial begin
      idle(3);
      check(!wake_ring && !wake_ri1 && !wake_ri2 && !wake_tm && !wake_any, "R1 outputs in reset",
            int'(wake_any), 0);
      rst_n = 1'b1;
      idle(1);
      check(!wake_any, "R1 first cycle after reset", int'(wake_any), 0);
      compare_on = 1'b1;
      idle(5);

      // R2 latency on ri1
      cfg_ri1_en = 1'b1;
      idle(2);
      ri1 = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(wake_ri1 == 1'b0, "R2 not before third edge", wake_ri1, 0);
      @(posedge clk);
      @(negedge clk);
      check(wake_ri1 == 1'b1, "R2 pulse at third edge", wake_ri1, 1);
      @(posedge clk);
      @(negedge clk);
      check(wake_ri1 == 1'b0, "R12 one cycle wide", wake_ri1, 0);
      ri1 = 1'b1;
      idle(10);

      // R4 edge mode on ring_a
      cfg_ring_en = 1'b1; cfg_src_sel = 1'b0; cfg_train_mode = 1'b0;
      clear_counts();
      pulses(0, 3, 10);
      idle(10);
      check(c_ring == 3, "R4 one pulse per falling edge", c_ring, 3);

      // R3 source select
      clear_counts();
      pulses(1, 2, 10);
      idle(10);
      check(c_ring == 0, "R3 ring_b ignored when sel=0", c_ring, 0);
      cfg_src_sel = 1'b1;
      idle(5);
      clear_counts();
      pulses(1, 2, 10);
      pulses(0, 2, 10);
      idle(10);
      check(c_ring == 2, "R3 ring_b used and ring_a ignored when sel=1", c_ring, 2);

      // R7 ring disabled
      cfg_ring_en = 1'b0;
      clear_counts();
      pulses(1, 3, 10);
      idle(10);
      check(c_ring == 0, "R7 ring disabled", c_ring, 0);

      // R5/R6 train mode on ring_b
      cfg_ring_en = 1'b1; cfg_train_mode = 1'b1;
      idle(50);
      clear_counts();
      pulses(1, 12, 8);
      idle(50);
      check(c_ring == 1, "R5 R6 long fast train gives one pulse", c_ring, 1);
      clear_counts();
      pulses(1, 12, 8);
      idle(50);
      check(c_ring == 1, "R6 re-armed after gap", c_ring, 1);
      clear_counts();
      pulses(1, 2, 8);
      idle(50);
      check(c_ring == 0, "R6 short train rejected", c_ring, 0);
      clear_counts();
      pulses(1, 6, 20);
      idle(50);
      check(c_ring == 0, "R6 slow train rejected", c_ring, 0);

      // R8 R9 ri enables
      cfg_ri1_en = 1'b0; cfg_ri2_en = 1'b1;
      clear_counts();
      pulses(2, 2, 10);
      pulses(3, 2, 10);
      idle(10);
      check(c_ri1 == 0, "R8 ri1 disabled", c_ri1, 0);
      check(c_ri2 == 2, "R9 ri2 enabled", c_ri2, 2);
      cfg_ri1_en = 1'b1; cfg_ri2_en = 1'b0;
      clear_counts();
      pulses(2, 2, 10);
      pulses(3, 2, 10);
      idle(10);
      check(c_ri1 == 2, "R8 ri1 enabled", c_ri1, 2);
      check(c_ri2 == 0, "R9 ri2 disabled", c_ri2, 0);

      // R11 simultaneous sources
      cfg_ri2_en = 1'b1;
      clear_counts();
      ri1 = 1'b0; ri2 = 1'b0;
      idle(6);
      ri1 = 1'b1; ri2 = 1'b1;
      idle(6);
      check(c_any == 1 && c_ri1 == 1 && c_ri2 == 1, "R11 simultaneous falls merge", c_any, 1);

      // R10 match path
      clear_counts();
      tm_match = 1'b1;
      idle(1);
      tm_match = 1'b0;
      idle(4);
      check(c_tm == 0, "R10 match disabled", c_tm, 0);
      cfg_tm_en = 1'b1;
      tm_match = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tm_match = 1'b0;
      check(wake_tm == 1'b1, "R10 match wake next cycle", wake_tm, 1);
      idle(4);
      check(c_tm == 1 && c_any == 1, "R10 R11 single match pulse", c_tm, 1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
   end
endmodule